// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous memory with a pipelined read path and a built-in burst sequencer, meant to act as a fast second-level store behind a processor. Every input is sampled on the rising clock edge. The sampled request goes into an access register. On the next rising edge that access is carried out against the array: a write updates the selected bytes, and a read loads the output register that drives the data pins.

A burst begins at one of two active-low start strobes. One belongs to the processor and always starts a read. The other belongs to the cache controller and starts a read or a write, as the write controls decide. After the start, an active-low advance input steps a 2-bit counter. The counter produces up to four addresses inside the aligned group of four words that holds the start address. A live mode pin picks either a wrapping increment or an XOR pattern for the low two address bits. A sleep input stops new accesses from being accepted. An asynchronous output enable releases the data pins.

The array depth is `2**ADDR_W` words. The default is kept small so the model elaborates quickly. Setting `ADDR_W` to 16 gives the full 65,536-word array with 64-bit words.

Top module: `pburst_sram`

## Requirements
- R1: After reset the output register holds zero, and no burst is active: an advance request with no prior start causes no access, so the outputs stay zero.
- R2: A read accepted at rising edge N puts the addressed word on `rdata` after rising edge N+1. It is valid at the falling edge that follows.
- R3: A cache-controller start (`ctl_start_n` low, `ce_n` low, `cpu_start_n` high) with active write controls writes `wdata` to `addr`. With no active write control it is a read of `addr`.
- R4: A processor start (`cpu_start_n` low, `ce_n` low) is always a read of `addr`, whatever the write controls are. When both strobes are low, the processor strobe wins.
- R5: When `all_wr_n` is low, an access writes all eight bytes, whatever `lane_gate_n` and `lane_wr_n` are.
- R6: When `all_wr_n` is high and `lane_gate_n` is low, lane k is written when `lane_wr_n[k]` is low. Lane k covers bits 8k+7..8k. When `lane_gate_n` is high, the lane inputs are ignored and nothing is written.
- R7: With a burst active and no start, `step_n` low advances the count by one, wrapping modulo 4. With `ilv_order` low, the low two address bits are (start + count) mod 4. The upper bits always stay those of the start address.
- R8: With `ilv_order` high, the low two address bits of a stepped access are the start address's low bits XOR the count.
- R9: With no start and `step_n` high, no access takes place and the output register keeps its value. With `ce_n` high, both strobes are ignored.
- R10: While `sleep` is high at an edge, no access is accepted, no byte is written and the burst count does not move. An access accepted at the previous edge still completes.
- R11: `oe_n` high releases `rdata` to high impedance without waiting for a clock edge. `oe_n` low drives the output register again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline and burst state |
| addr | input | ADDR_W | Word address, used on a start |
| wdata | input | DATA_W | Write data |
| ce_n | input | 1 | Active-low enable for burst starts |
| cpu_start_n | input | 1 | Processor burst-start strobe, active low, read only |
| ctl_start_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| ilv_order | input | 1 | 1: XOR burst order, 0: wrapping increment order |
| all_wr_n | input | 1 | Write-all-bytes control, active low |
| lane_gate_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | DATA_W/8 | Per-byte write selects, active low |
| sleep | input | 1 | Power-down: blocks accepting accesses |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Read data, high impedance when disabled |

## Verification
The checker tests, on every edge, how requests are classified. A processor start must become a read, and a write-all controller start must select all lanes. Sleep and idle cycles must produce an empty access slot. A stepped access must keep the start address's upper bits, and an empty slot must leave the output register unchanged. The bench scenarios are needed to show the actual data: byte merges into stored words, the two burst orders and count wrap-around, the two-edge read latency, the counter freezing during sleep, and the asynchronous release of the outputs.

// File: rtl/pburst_pkg.sv
package pburst_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low two address bits of a burst word: XOR pattern or wrapping add
    function automatic logic [1:0] burst_low(input logic [1:0] origin,
                                             input logic [1:0] count,
                                             input logic       ilv);
        return ilv ? (origin ^ count) : (origin + count);
    endfunction

endpackage

// File: rtl/pburst_seq.sv
module pburst_seq
    import pburst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    output logic              go,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              live,
    output logic [ADDR_W-3:0] base_hi
);

    typedef struct packed {
        logic              live;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        go       = 1'b0;
        cur_addr = st_q.base;
        if (start) begin
            st_d.live = 1'b1;
            st_d.base = addr;
            st_d.cnt  = 2'd0;
            go        = 1'b1;
            cur_addr  = addr;
        end else if (step && st_q.live) begin
            st_d.cnt = st_q.cnt + 2'd1;
            go       = 1'b1;
            cur_addr = {st_q.base[ADDR_W-1:2],
                        burst_low(st_q.base[1:0], st_d.cnt, ilv)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live    = st_q.live;
    assign base_hi = st_q.base[ADDR_W-1:2];

endmodule

// File: rtl/pburst_array.sv
module pburst_array
    import pburst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  op_e                 op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    input  logic [DATA_W/8-1:0] lanes,
    output logic [DATA_W-1:0]   dout
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_d, dout_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lanes[g])
                bank[addr] <= data[g*8 +: 8];
        end

        assign rd_word[g*8 +: 8] = bank[addr];
    end

    always_comb begin
        dout_d = dout_q;
        if (op == OP_READ) dout_d = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign dout = dout_q;

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pburst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                ce_n,
    input  logic                cpu_start_n,
    input  logic                ctl_start_n,
    input  logic                step_n,
    input  logic                ilv_order,
    input  logic                all_wr_n,
    input  logic                lane_gate_n,
    input  logic [DATA_W/8-1:0] lane_wr_n,
    input  logic                sleep,
    input  logic                oe_n,
    output logic [DATA_W-1:0]   rdata
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  lanes;
    } acc_t;

    acc_t acc_d, acc_q;

    logic              start_cpu, start_ctl, start_any, step_req;
    logic              seq_go, seq_live;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-3:0] seq_base_hi;
    logic [LANES-1:0]  lanes_req;
    logic [DATA_W-1:0] arr_dout;

    always_comb begin
        start_cpu = !sleep && !ce_n && !cpu_start_n;
        start_ctl = !sleep && !ce_n && cpu_start_n && !ctl_start_n;
        start_any = start_cpu || start_ctl;
        step_req  = !sleep && !start_any && !step_n;
        if (!all_wr_n)         lanes_req = '1;
        else if (!lane_gate_n) lanes_req = ~lane_wr_n;
        else                   lanes_req = '0;
    end

    pburst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_any),
        .step     (step_req),
        .ilv      (ilv_order),
        .addr     (addr),
        .go       (seq_go),
        .cur_addr (seq_addr),
        .live     (seq_live),
        .base_hi  (seq_base_hi)
    );

    always_comb begin
        acc_d.addr  = seq_addr;
        acc_d.data  = wdata;
        acc_d.lanes = '0;
        if (!seq_go) begin
            acc_d.op = OP_IDLE;
        end else if (start_cpu || lanes_req == '0) begin
            acc_d.op = OP_READ;
        end else begin
            acc_d.op    = OP_WRITE;
            acc_d.lanes = lanes_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '{op: OP_IDLE, default: '0};
        else        acc_q <= acc_d;
    end

    pburst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (acc_q.op),
        .addr  (acc_q.addr),
        .data  (acc_q.data),
        .lanes (acc_q.lanes),
        .dout  (arr_dout)
    );

    assign rdata = oe_n ? {DATA_W{1'bz}} : arr_dout;

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk
    import pburst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep,
    input logic                ce_n,
    input logic                cpu_start_n,
    input logic                ctl_start_n,
    input logic                step_n,
    input logic                all_wr_n,
    input op_e                 acc_op,
    input logic [DATA_W/8-1:0] acc_lanes,
    input logic [ADDR_W-3:0]   acc_hi,
    input logic [ADDR_W-3:0]   base_hi,
    input logic                live,
    input logic [DATA_W-1:0]   dout
);

    logic no_start;
    assign no_start = ce_n || (cpu_start_n && ctl_start_n);

    a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ce_n && !cpu_start_n) |=> (acc_op == OP_READ));

    a_r5_write_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ce_n && cpu_start_n && !ctl_start_n && !all_wr_n)
        |=> (acc_op == OP_WRITE && (&acc_lanes)));

    a_r7_step_keeps_group: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && live && !step_n && no_start) |=> (acc_hi == $past(base_hi)));

    a_r9_no_request_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && step_n && no_start) |=> (acc_op == OP_IDLE));

    a_r9_idle_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == OP_IDLE) |=> $stable(dout));

    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (acc_op == OP_IDLE));

endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .ce_n        (ce_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .step_n      (step_n),
    .all_wr_n    (all_wr_n),
    .acc_op      (acc_q.op),
    .acc_lanes   (acc_q.lanes),
    .acc_hi      (acc_q.addr[ADDR_W-1:2]),
    .base_hi     (seq_base_hi),
    .live        (seq_live),
    .dout        (arr_dout)
);

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          ce_n, cpu_start_n, ctl_start_n, step_n, ilv_order;
    logic          all_wr_n, lane_gate_n, sleep, oe_n;
    logic [7:0]    lane_wr_n;
    wire  [DW-1:0] rdata;

    pburst_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
        .ilv_order(ilv_order), .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n),
        .lane_wr_n(lane_wr_n), .sleep(sleep), .oe_n(oe_n), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        logic [63:0] val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model [int];
    logic [63:0] last_out = '0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: pops due expectations at each falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, rdata, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            report();
            $finish;
        end
    end

    function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [7:0] en);
        logic [63:0] r = old;
        for (int k = 0; k < 8; k++) if (en[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r;
    endfunction

    function automatic int baddr(int base, int k, bit ilv);
        int lo = ilv ? ((base ^ k) & 3) : ((base + k) & 3);
        return (base & ~3) | lo;
    endfunction

    function automatic logic [63:0] rd_model(int a);
        return model.exists(a) ? model[a] : 64'h0;
    endfunction

    task automatic expect_val(logic [63:0] v, string tag);
        exp_t e;
        e.due = cyc + 2; e.val = v; e.tag = tag;
        sb.push_back(e);
        last_out = v;
    endtask

    task automatic expect_hold(string tag);
        expect_val(last_out, tag);
    endtask

    task automatic idle_inputs();
        ce_n = 0; cpu_start_n = 1; ctl_start_n = 1; step_n = 1;
        all_wr_n = 1; lane_gate_n = 1; lane_wr_n = 8'hFF; sleep = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    // controller start; write if any control is active, else read
    task automatic ctl_start(int a, logic [63:0] d, bit gw_n, bit gate_n,
                             logic [7:0] ln, string tag);
        logic [7:0] en;
        addr = AW'(a); wdata = d; ctl_start_n = 0;
        all_wr_n = gw_n; lane_gate_n = gate_n; lane_wr_n = ln;
        en = !gw_n ? 8'hFF : (!gate_n ? ~ln : 8'h00);
        if (en != 0) model[a] = merge(rd_model(a), d, en);
        else         expect_val(rd_model(a), tag);
        tick();
    endtask

    task automatic cpu_read(int a, bit with_wr, string tag);
        addr = AW'(a); wdata = 64'hDEAD_BEEF_0BAD_F00D; cpu_start_n = 0;
        if (with_wr) begin all_wr_n = 0; ctl_start_n = 0; end
        expect_val(rd_model(a), tag);
        tick();
    endtask

    task automatic step_read(int a, string tag);
        step_n = 0;
        expect_val(rd_model(a), tag);
        tick();
    endtask

    task automatic step_write(int a, logic [63:0] d);
        step_n = 0; all_wr_n = 0; wdata = d;
        model[a] = d;
        tick();
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        ilv_order = 1; oe_n = 0; addr = '0; wdata = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, and an advance without a start does nothing
        check("R1 reset output", rdata, 64'h0);
        step_n = 0; expect_hold("R1 advance before any start"); tick();
        drain();

        // R3/R5/R2: write-all through controller start, read back
        ctl_start(5, 64'h1111_2222_3333_4444, 0, 1, 8'hFF, "R3");
        ctl_start(6, 64'hA5A5_5A5A_0F0F_F0F0, 0, 0, 8'h00, "R5");
        cpu_read(5, 0, "R2 read latency");
        cpu_read(6, 0, "R5 write-all with lanes");
        // R3: controller start without write controls is a read
        ctl_start(5, 64'h0, 1, 1, 8'hFF, "R3 controller read");

        // R6: lanes 1 and 3 written when the gate is low
        ctl_start(6, 64'hFFEE_DDCC_BBAA_9988, 1, 0, 8'b1111_0101, "R6");
        cpu_read(6, 0, "R6 lane merge");
        // R6: gate high ignores lanes (acts as a read, contents kept)
        ctl_start(6, 64'h0, 1, 1, 8'h00, "R6 gate high no write");
        cpu_read(6, 0, "R6 contents after gated attempt");

        // R4: processor start ignores write controls; both strobes -> read
        cpu_read(5, 1, "R4 processor start reads");
        cpu_read(5, 0, "R4 no write happened");

        // prepare group 16..19 and 32..35
        for (int i = 0; i < 4; i++)
            ctl_start(16 + i, 64'h1600 + 64'(i) * 64'h1_0001, 0, 1, 8'hFF, "R3");

        // R7: wrapping increment from 17, including wrap of the count
        ilv_order = 0;
        cpu_read(17, 0, "R7 start");
        for (int k = 1; k < 5; k++) step_read(baddr(17, k & 3, 0), "R7 linear step");
        // R8: XOR order from 17
        ilv_order = 1;
        cpu_read(17, 0, "R8 start");
        for (int k = 1; k < 4; k++) step_read(baddr(17, k, 1), "R8 xor step");

        // R3/R7: burst write from 34, linear order
        ilv_order = 0;
        ctl_start(34, 64'h3400, 0, 1, 8'hFF, "R3");
        for (int k = 1; k < 4; k++) step_write(baddr(34, k, 0), 64'h3400 + 64'(k));
        for (int a = 32; a < 36; a++) cpu_read(a, 0, "R7 burst write contents");

        // R9: idle cycle and disabled starts leave the output alone
        cpu_read(16, 0, "R9 setup");
        expect_hold("R9 idle hold"); tick();
        ce_n = 1; cpu_start_n = 0; addr = AW'(5);
        expect_hold("R9 ce_n high ignores strobe"); tick();

        // R10: sleep freezes the count and blocks accesses
        cpu_read(16, 0, "R10 setup");
        sleep = 1; step_n = 0; expect_hold("R10 sleep holds output"); tick();
        step_read(17, "R10 count frozen during sleep");
        sleep = 1; ctl_start_n = 0; all_wr_n = 0; addr = AW'(5); wdata = 64'hBAD;
        expect_hold("R10 sleep write blocked"); tick();
        cpu_read(5, 0, "R10 no write while sleeping");
        drain();

        // R11: asynchronous output release
        @(negedge clk);
        oe_n = 1; #1;
        checks++;
        if (rdata === last_out) begin
            errors++;
            $display("FAIL R11 actual=%h expected=released", rdata);
        end
        oe_n = 0; #1;
        check("R11 drive restored", rdata, last_out);

        repeat (2) @(negedge clk);
        finished = 1;
        report();
        $finish;
    end

endmodule